// File: doc/BRIEF.md
# Tree-Structured 16:1 Serializer

This block turns a 16-bit parallel word into a serial stream, one bit per full-rate clock cycle. A 4-bit phase counter in the full-rate domain stands in for the divide-by-16, divide-by-8, divide-by-4 and divide-by-2 clocks. It produces one-cycle enable pulses, so every register runs on the one full-rate clock.

A word is sampled into a holding register at the midpoint of each low-speed period, which is the falling phase of the divide-by-16 clock. Half a period later it is launched into the 16-bit root of a binary tree. Each level of the tree halves the width through 2:1 selection: 16 to 8, 8 to 4, 4 to 2, and 2 to 1. Each level reloads at the rate of its divided clock, and the last level is the serial output register.

The full-rate clock comes from one of two sources. One is the internally generated clock; the other is an external full-rate clock, used when the internal loop is switched off. The integrator sees two clock pins and a source select, drives one word per low-speed period, and receives the bits lowest index first.

Top module: `ser16_tree_top`

## Requirements
- R1: A synchronous active-high `rst` clears the phase counter and every data register. `ser_out` is 0 during reset. It stays 0 on the first 19 clock edges after reset is released, until the first captured word reaches the output.
- R2: After reset the phase count starts at 0 and advances by one per edge, modulo 16. `word_in` is sampled on every edge whose phase count is 7, which is the falling phase of the low-speed clock (high for counts 0 to 7). The first such edge is the 8th after release, and the next ones follow every 16 edges.
- R3: A value on `word_in` at any edge other than a capture edge has no effect on the serial stream.
- R4: Each word leaves one bit per clock cycle, bit 0 first and bit 15 last.
- R5: Count the capture edge as edge 0. Bit j of the captured word is on `ser_out` from edge 12+j until the next edge.
- R6: Words captured at consecutive capture edges form a gap-free stream: bit 15 of one word is directly followed by bit 0 of the next.
- R7: The held word is launched into the 16-bit tree root at phase count 15. Each narrower tree level changes only on the edges of its own divided-clock enable.
- R8: With `clk_src_sel` = 0 the block runs on `clk_int`. With `clk_src_sel` = 1 it runs on `clk_ext`. The clock that is not selected has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Internally generated full-rate clock |
| clk_ext | input | 1 | External full-rate clock, used when the internal loop is off |
| clk_src_sel | input | 1 | Clock source select: 0 internal, 1 external |
| rst | input | 1 | Synchronous active-high reset |
| word_in | input | 16 | Parallel word; bit 0 is sent first |
| ser_out | output | 1 | Serial data, one bit per full-rate cycle |

## Verification
The assertions check four things on every cycle:
- the holding register changes only on capture edges;
- the tree root always receives the held word on the launch edge;
- the 8-bit level stays still outside its enable;
- the output is quiet for the fixed delay after reset.

Only the bench scenarios can show the end-to-end behaviour: the bit order, the exact 12-cycle offset and the seamless joining of back-to-back words. They also show that junk on `word_in` between capture edges never leaks into the stream. The effect of the clock source select is visible only when the bench stops the unselected clock and the stream still advances.

// File: rtl/ser_tree_pkg.sv
package ser_tree_pkg;

    typedef enum logic {
        CLK_SRC_INT = 1'b0,
        CLK_SRC_EXT = 1'b1
    } clk_src_e;

    // Bit offset of tree level k inside a flat bus that holds all levels,
    // level 0 being the full word and each further level half as wide.
    function automatic int lvl_off(input int width, input int k);
        return 2 * width - 2 * (width >> k);
    endfunction

endpackage

// File: rtl/ser_clk_sel.sv
module ser_clk_sel
    import ser_tree_pkg::*;
(
    input  logic clk_int,
    input  logic clk_ext,
    input  logic src_sel,
    output logic clk_out
);

    clk_src_e src;

    assign src = clk_src_e'(src_sel);

    // Source change is meant to happen only while reset is held.
    always_comb begin
        clk_out = (src == CLK_SRC_EXT) ? clk_ext : clk_int;
    end

endmodule

// File: rtl/ser_phase_gen.sv
module ser_phase_gen #(
    parameter int LEVELS = 4
) (
    input  logic              clk,
    input  logic              rst,
    output logic              cap_en,
    output logic              launch_en,
    output logic [LEVELS-1:0] lvl_ld,
    output logic [LEVELS-1:0] lvl_hi
);

    localparam int NW = 1 << LEVELS;
    localparam int CW = LEVELS;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } phase_t;

    phase_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
        if (rst) begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // Divide-by-N clock is high for the first half of the count: its
    // falling phase samples the word, the wrap launches it into the tree.
    assign cap_en    = (st_q.cnt == CW'(NW / 2 - 1));
    assign launch_en = (st_q.cnt == CW'(NW - 1));

    // Level k (1..LEVELS) lags level k-1 by one edge; its enable fires when
    // the shifted count hits zero modulo its period, and the next bit up
    // tells which half of the wider level to take.
    for (genvar k = 1; k <= LEVELS; k++) begin : g_lvl
        localparam int RW = LEVELS - k + 1;
        logic [RW-1:0] rel;

        assign rel = st_q.cnt[RW-1:0] - RW'(k - 1);

        if (k == LEVELS) begin : g_full_rate
            assign lvl_ld[k-1] = 1'b1;
        end else begin : g_divided
            assign lvl_ld[k-1] = (rel[RW-2:0] == '0);
        end

        assign lvl_hi[k-1] = rel[RW-1];
    end

endmodule

// File: rtl/ser_word_capture.sv
module ser_word_capture #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_en,
    input  logic             launch_en,
    input  logic [WIDTH-1:0] word_in,
    output logic [WIDTH-1:0] hold,
    output logic [WIDTH-1:0] root
);

    typedef struct packed {
        logic [WIDTH-1:0] hold;
        logic [WIDTH-1:0] root;
    } cap_t;

    cap_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap_en) begin
            st_d.hold = word_in;
        end
        if (launch_en) begin
            st_d.root = st_q.hold;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign hold = st_q.hold;
    assign root = st_q.root;

endmodule

// File: rtl/ser_tree_stage.sv
module ser_tree_stage #(
    parameter int IN_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic              hi,
    input  logic [IN_W-1:0]   din,
    output logic [IN_W/2-1:0] dout
);

    localparam int OW = IN_W / 2;

    typedef struct packed {
        logic [OW-1:0] data;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld) begin
            st_d.data = hi ? din[IN_W-1:OW] : din[OW-1:0];
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout = st_q.data;

endmodule

// File: rtl/ser16_tree_top.sv
module ser16_tree_top
    import ser_tree_pkg::*;
#(
    parameter  int LEVELS = 4,
    localparam int WIDTH  = 1 << LEVELS
) (
    input  logic             clk_int,
    input  logic             clk_ext,
    input  logic             clk_src_sel,
    input  logic             rst,
    input  logic [WIDTH-1:0] word_in,
    output logic             ser_out
);

    localparam int BUS_W = 2 * WIDTH - 1;

    logic              fclk;
    logic              cap_en;
    logic              launch_en;
    logic [LEVELS-1:0] lvl_ld;
    logic [LEVELS-1:0] lvl_hi;
    logic [WIDTH-1:0]  hold_w;
    logic [BUS_W-1:0]  tree_bus;

    ser_clk_sel u_clk_sel (
        .clk_int (clk_int),
        .clk_ext (clk_ext),
        .src_sel (clk_src_sel),
        .clk_out (fclk)
    );

    ser_phase_gen #(
        .LEVELS (LEVELS)
    ) u_phase (
        .clk       (fclk),
        .rst       (rst),
        .cap_en    (cap_en),
        .launch_en (launch_en),
        .lvl_ld    (lvl_ld),
        .lvl_hi    (lvl_hi)
    );

    ser_word_capture #(
        .WIDTH (WIDTH)
    ) u_capture (
        .clk       (fclk),
        .rst       (rst),
        .cap_en    (cap_en),
        .launch_en (launch_en),
        .word_in   (word_in),
        .hold      (hold_w),
        .root      (tree_bus[WIDTH-1:0])
    );

    for (genvar k = 1; k <= LEVELS; k++) begin : g_tree
        localparam int IN_OFF  = lvl_off(WIDTH, k - 1);
        localparam int OUT_OFF = lvl_off(WIDTH, k);
        localparam int IN_W    = WIDTH >> (k - 1);

        ser_tree_stage #(
            .IN_W (IN_W)
        ) u_stage (
            .clk  (fclk),
            .rst  (rst),
            .ld   (lvl_ld[k-1]),
            .hi   (lvl_hi[k-1]),
            .din  (tree_bus[IN_OFF +: IN_W]),
            .dout (tree_bus[OUT_OFF +: IN_W/2])
        );
    end

    assign ser_out = tree_bus[BUS_W-1];

endmodule

// File: rtl/ser16_tree_chk.sv
module ser16_tree_chk #(
    parameter int LEVELS = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   cap_en,
    input logic                   launch_en,
    input logic                   ld_first,
    input logic [(1<<LEVELS)-1:0] hold,
    input logic [(1<<LEVELS)-1:0] root,
    input logic [(1<<LEVELS)/2-1:0] lvl1,
    input logic                   ser_out
);

    localparam int WIDTH = 1 << LEVELS;
    localparam int FIRST = WIDTH / 2 + WIDTH / 2 + LEVELS;

    int since_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= 0;
        end else if (since_q < FIRST) begin
            since_q <= since_q + 1;
        end
    end

    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        (since_q < FIRST) |-> !ser_out);

    assert_hold_only_on_capture_R2: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> $stable(hold));

    assert_root_takes_hold_R7: assert property (@(posedge clk) disable iff (rst)
        launch_en |=> (root == $past(hold)));

    assert_lvl1_only_on_enable_R7: assert property (@(posedge clk) disable iff (rst)
        !ld_first |=> $stable(lvl1));

endmodule

bind ser16_tree_top ser16_tree_chk #(
    .LEVELS (LEVELS)
) u_chk (
    .clk       (fclk),
    .rst       (rst),
    .cap_en    (cap_en),
    .launch_en (launch_en),
    .ld_first  (lvl_ld[0]),
    .hold      (hold_w),
    .root      (tree_bus[WIDTH-1:0]),
    .lvl1      (tree_bus[WIDTH +: WIDTH/2]),
    .ser_out   (ser_out)
);

// File: tb/tb_ser16_tree_top.sv
module tb_ser16_tree_top;

    localparam int LV    = 4;
    localparam int N     = 1 << LV;
    localparam int HALF  = N / 2;
    localparam int LAT   = HALF + LV;
    localparam int FIRST = HALF + LAT;
    localparam int DEPTH = 4096;

    logic         clk_int = 1'b0;
    logic         clk_ext = 1'b0;
    logic         run_int = 1'b1;
    logic         run_ext = 1'b0;
    logic         use_ext = 1'b0;
    logic         clk_src_sel = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] word_in = '0;
    logic         ser_out;
    logic         tclk;

    int n_chk = 0;
    int n_bad = 0;
    int e     = 0;
    int mc    = 0;
    logic expv [DEPTH];

    always #10 clk_int = run_int ? ~clk_int : 1'b0;
    always #10 clk_ext = run_ext ? ~clk_ext : 1'b0;
    assign tclk = use_ext ? clk_ext : clk_int;

    ser16_tree_top dut (
        .clk_int     (clk_int),
        .clk_ext     (clk_ext),
        .clk_src_sel (clk_src_sel),
        .rst         (rst),
        .word_in     (word_in),
        .ser_out     (ser_out)
    );

    task automatic check(input logic ok, input string req, input int act, input int expd);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s edge %0d: actual %0d expected %0d", req, e, act, expd);
        end
    endtask

    task automatic do_reset(input logic ext);
        rst = 1'b1;
        #5;
        run_int     = !ext;
        run_ext     = ext;
        use_ext     = ext;
        clk_src_sel = ext;
        #40;
        for (int i = 0; i < 4; i++) begin
            @(posedge tclk);
            @(negedge tclk);
            check(ser_out === 1'b0, "R1 in reset", int'(ser_out), 0);
        end
        for (int i = 0; i < DEPTH; i++) expv[i] = 1'b0;
        e       = 0;
        mc      = 0;
        word_in = N'($urandom);
        rst     = 1'b0;
    endtask

    // One clock: model the capture at phase count 7 (R2), then check the output.
    task automatic step(input logic [N-1:0] pat, input string tag);
        string t;
        @(posedge tclk);
        e++;
        if (mc == HALF - 1) begin
            for (int j = 0; j < N; j++) begin
                if (e + LAT + j < DEPTH) expv[e + LAT + j] = word_in[j];
            end
        end
        mc = (mc + 1) % N;
        @(negedge tclk);
        t = tag;
        if (e < FIRST) t = "R1 quiet after release";
        check(ser_out === expv[e], t, int'(ser_out), int'(expv[e]));
        // Junk on every non-capture edge exercises R3.
        word_in = (mc == HALF - 1) ? pat : N'($urandom);
    endtask

    task automatic send_word(input logic [N-1:0] pat, input string tag);
        for (int i = 0; i < N; i++) step(pat, tag);
    endtask

    initial begin
        do_reset(1'b0);
        // Directed words: order (R4), offset (R5), joins (R6), tree (R7), capture (R2).
        send_word(16'h0001, "R2 R4 R5 R7 d00 first");
        send_word(16'h8000, "R4 R5 R6 d15 last");
        send_word(16'hFFFF, "R5 R6 all ones");
        send_word(16'h0000, "R5 R6 all zeros");
        send_word(16'hA5C3, "R4 R7 mixed");
        send_word(16'h0180, "R4 R7 middle bits");
        // Random back-to-back words with junk between capture edges.
        for (int w = 0; w < 60; w++) send_word(N'($urandom), "R3 R5 R6 R7 random");
        for (int w = 0; w < 2; w++) send_word(16'h0000, "R5 flush");

        // External clock only; internal clock stopped.
        do_reset(1'b1);
        for (int w = 0; w < 12; w++) send_word(N'($urandom), "R8 external clock");
        send_word(16'h0000, "R8 flush");

        // Back to the internal clock with words still in flight (R1, R8).
        for (int w = 0; w < 3; w++) send_word(N'($urandom), "R8 external clock");
        do_reset(1'b0);
        for (int w = 0; w < 10; w++) send_word(N'($urandom), "R8 R1 internal after reset");
        for (int w = 0; w < 2; w++) send_word(16'h0000, "R5 flush");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule